// File: doc/BRIEF.md
# Speculative Store Conservative-Mode Controller

This block tells a processor's memory pipeline when to refuse new miss requests that come from speculative stores. Refusing them avoids a livelock between processors that run load-locked / store-conditional loops. A store that misses speculatively on one processor can take a line away from another processor. The second processor's store-conditional then keeps failing.

A 2-bit mode field chooses how cautious the processor is. In the off setting, nothing is blocked. In the always setting, speculative store misses are blocked on every cycle. The periodic setting blocks in two cases:

- A branch-event counter is nonzero. The counter rises on branch mispredicts and falls on conditional-branch retires.
- A long-period backup timer is in the short window at the start of its period.

Writing the off setting resets the backup timer. Software can write off to every processor at the same time, and their windows then line up.

The output is registered. It follows the counter and timer state with one cycle of latency. The timer period and the window length are parameters, so that a test setup can shorten them. By default the period is 2^21 cycles and the window is 16384 cycles.

Top module: `ssc_conservative_ctl`

## Requirements
- R1: With mode 2'b00 (off), `block_spec_store_miss` is low on the cycle after every edge, whatever the branch pulses do.
- R2: With mode 2'b01 (always), `block_spec_store_miss` is high on the cycle after every edge, whatever the counter and timer hold.
- R3: In periodic mode, a mispredict pulse without a retire pulse increments the branch counter (CNT_W bits, default 8). The counter saturates at 2^CNT_W-1.
- R4: In periodic mode, a retire pulse without a mispredict pulse decrements the branch counter. The counter stops at 0.
- R5: When both pulses arrive in the same cycle, the branch counter keeps its value.
- R6: Outside periodic mode, the branch counter is held at 0, so it re-enters periodic mode empty.
- R7: In periodic mode, the output is high exactly when the branch counter is nonzero or the backup window is active.
- R8: While periodic mode is selected, the backup timer advances once per cycle and wraps after PERIOD cycles. The window is active for the first WINDOW counts of each period.
- R9: Mode 2'b00 resets the backup timer to 0. Mode 2'b01 freezes the timer without resetting it.
- R10: Mode 2'b11 behaves exactly like 2'b10 (periodic).
- R11: The output is registered. It reflects the mode, counter and timer state that were present before the clock edge.
- R12: A synchronous active-high reset clears both counters and drives the output low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Conservative-mode select: 00 off, 01 always, 10/11 periodic |
| mispredict | input | 1 | One-cycle pulse per branch mispredict |
| branch_retire | input | 1 | One-cycle pulse per conditional-branch retire |
| block_spec_store_miss | output | 1 | Registered request to block speculative store miss allocation |

## Verification
The following are checked by assertions on every cycle:

- The output follows the off, always and reset settings.
- The counter saturates at the top and stops at 0.
- The counter holds when both pulses arrive together, and is held at 0 outside periodic mode.
- The timer wraps after PERIOD counts, is cleared in the off setting, and is frozen in the always setting.

Some behaviour can only be shown by the bench's scenarios. These are the exact placement of the windows inside the period, the restart of the window after the off setting is written, the equivalence of code 11 and code 10, and the combined effect of the counter and the window on the registered output. The bench shows them by comparing the output with an independent model on every cycle.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [1:0] {
    SSC_OFF        = 2'b00,
    SSC_ALWAYS     = 2'b01,
    SSC_PERIODIC   = 2'b10,
    SSC_PERIODIC_B = 2'b11
  } ssc_mode_e;

  typedef struct packed {
    logic always_on;
    logic periodic_on;
    logic timer_clear;
  } ssc_ctrl_t;

endpackage

// File: rtl/ssc_mode_decode.sv
module ssc_mode_decode
  import ssc_pkg::*;
(
  input  logic [1:0] mode,
  output ssc_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (ssc_mode_e'(mode))
      SSC_OFF:        ctrl.timer_clear = 1'b1;
      SSC_ALWAYS:     ctrl.always_on   = 1'b1;
      SSC_PERIODIC,
      SSC_PERIODIC_B: ctrl.periodic_on = 1'b1;
      default:        ctrl = '0;
    endcase
  end

  // R10: both periodic codes map to the same control, and the controls stay exclusive.
  always_comb begin
    assert_exclusive_R10: assert ($onehot0({ctrl.always_on, ctrl.periodic_on, ctrl.timer_clear}));
  end

endmodule

// File: rtl/ssc_branch_counter.sv
module ssc_branch_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mispredict,
  input  logic             branch_retire,
  output logic [CNT_W-1:0] count,
  output logic             nonzero
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      count <= '0;
    end else begin
      case ({mispredict, branch_retire})
        2'b10:   if (count != CNT_MAX) count <= count + 1'b1;
        2'b01:   if (count != '0)      count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign nonzero = |count;

  assert_saturate_R3: assert property (@(posedge clk) disable iff (rst)
    (en && mispredict && !branch_retire && count == CNT_MAX) |=> (count == CNT_MAX));

  assert_floor_R4: assert property (@(posedge clk) disable iff (rst)
    (en && branch_retire && !mispredict && count == '0) |=> (count == '0));

  assert_both_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (en && mispredict && branch_retire) |=> $stable(count));

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> (count == '0));

endmodule

// File: rtl/ssc_backup_timer.sv
module ssc_backup_timer #(
  parameter int PERIOD = 2**21,
  parameter int WINDOW = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic window
);

  localparam int          TW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);
  localparam logic [TW-1:0] WIN  = TW'(WINDOW);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst || clear)   tmr <= '0;
    else if (run)       tmr <= (tmr == LAST) ? '0 : tmr + 1'b1;
  end

  assign window = run && (tmr < WIN);

  assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (run && !clear && tmr == LAST) |=> (tmr == '0));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clear |=> (tmr == '0));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(tmr));

endmodule

// File: rtl/ssc_conservative_ctl.sv
module ssc_conservative_ctl
  import ssc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PERIOD = 2**21,
  parameter int WINDOW = 16384
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       mispredict,
  input  logic       branch_retire,
  output logic       block_spec_store_miss
);

  ssc_ctrl_t        ctrl;
  logic [CNT_W-1:0] br_count;
  logic             br_nonzero;
  logic             bk_window;
  logic             conservative;

  ssc_mode_decode u_decode (
    .mode (mode),
    .ctrl (ctrl)
  );

  ssc_branch_counter #(.CNT_W(CNT_W)) u_branch (
    .clk           (clk),
    .rst           (rst),
    .en            (ctrl.periodic_on),
    .mispredict    (mispredict),
    .branch_retire (branch_retire),
    .count         (br_count),
    .nonzero       (br_nonzero)
  );

  ssc_backup_timer #(.PERIOD(PERIOD), .WINDOW(WINDOW)) u_backup (
    .clk    (clk),
    .rst    (rst),
    .run    (ctrl.periodic_on),
    .clear  (ctrl.timer_clear),
    .window (bk_window)
  );

  assign conservative = ctrl.always_on | (ctrl.periodic_on & (br_nonzero | bk_window));

  always_ff @(posedge clk) begin
    if (rst) block_spec_store_miss <= 1'b0;
    else     block_spec_store_miss <= conservative;
  end

  assert_off_R1: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> !block_spec_store_miss);

  assert_always_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> block_spec_store_miss);

  assert_counter_R7: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && br_count != '0) |=> block_spec_store_miss);

  assert_reset_R12: assert property (@(posedge clk)
    rst |=> !block_spec_store_miss);

endmodule

// File: tb/tb_ssc_conservative_ctl.sv
module tb_ssc_conservative_ctl;

  localparam int CNT_W  = 8;
  localparam int PERIOD = 32;
  localparam int WINDOW = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       mispredict = 1'b0;
  logic       branch_retire = 1'b0;
  logic       block_spec_store_miss;

  always #4 clk = ~clk;

  ssc_conservative_ctl #(.CNT_W(CNT_W), .PERIOD(PERIOD), .WINDOW(WINDOW)) dut (
    .clk                   (clk),
    .rst                   (rst),
    .mode                  (mode),
    .mispredict            (mispredict),
    .branch_retire         (branch_retire),
    .block_spec_store_miss (block_spec_store_miss)
  );

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  item_t q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;

  // Reference model built from the requirements
  int m_cnt = 0;
  int m_tmr = 0;

  task automatic step(input bit r, input logic [1:0] m, input bit mis, input bit ret,
                      input string tag);
    item_t it;
    bit    periodic;
    @(negedge clk);
    rst = r; mode = m; mispredict = mis; branch_retire = ret;
    periodic = m[1];                                   // R10
    if (r) begin                                       // R12
      it.exp = 1'b0; m_cnt = 0; m_tmr = 0;
    end else begin
      // R1, R2, R7 decision, registered (R11)
      it.exp = (m == 2'b01) || (periodic && (m_cnt != 0 || m_tmr < WINDOW));
      if (!periodic) m_cnt = 0;                        // R6
      else if (mis && !ret) m_cnt = (m_cnt == CMAX) ? CMAX : m_cnt + 1;  // R3
      else if (ret && !mis) m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;        // R4
      // both: hold (R5)
      if (m == 2'b00) m_tmr = 0;                       // R9
      else if (periodic) m_tmr = (m_tmr == PERIOD - 1) ? 0 : m_tmr + 1;  // R8
    end
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run(input int n, input bit r, input logic [1:0] m, input bit mis,
                     input bit ret, input string tag);
    for (int i = 0; i < n; i++) step(r, m, mis, ret, tag);
  endtask

  // Monitor: pops one expected item per edge and compares
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        n_tests++;
        if (block_spec_store_miss !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual=%b expected=%b at %0t", it.tag,
                   block_spec_store_miss, it.exp, $time);
        end
      end
    end
  end

  initial begin
    run(3,  1, 2'b10, 1, 0, "R12 reset state");
    run(6,  0, 2'b00, 1, 0, "R1 off ignores mispredict");
    run(3,  0, 2'b00, 0, 0, "R6 counter empty after off");
    run(70, 0, 2'b10, 0, 0, "R8 periodic windows");
    run(3,  0, 2'b10, 1, 0, "R3 count up");
    run(4,  0, 2'b10, 1, 1, "R5 both pulses hold");
    run(6,  0, 2'b10, 0, 1, "R4 count down to floor");
    run(40, 0, 2'b10, 0, 0, "R7 idle periodic");
    run(CMAX + 6, 0, 2'b10, 1, 0, "R3 saturate");
    run(CMAX, 0, 2'b10, 0, 1, "R4 drain from top");
    run(5,  0, 2'b10, 0, 1, "R4 floor after drain");
    run(10, 0, 2'b01, 0, 1, "R2 always on");
    run(30, 0, 2'b10, 0, 0, "R9 timer frozen in always");
    run(20, 0, 2'b11, 0, 0, "R10 code 11 periodic");
    run(4,  0, 2'b11, 1, 0, "R10 code 11 counts");
    run(2,  0, 2'b00, 0, 0, "R9 off clears timer");
    run(40, 0, 2'b10, 0, 0, "R9 window restarts");
    run(2,  0, 2'b10, 0, 0, "R11 registered output");
    run(2,  1, 2'b01, 0, 0, "R12 mid-run reset");
    run(10, 0, 2'b10, 0, 0, "R12 timer restarts after reset");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule